// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a context table entry and then descending through up to three levels of page tables held in memory. Every entry it fetches carries a 2-bit type in its lowest bits. A table descriptor sends the walk one level deeper. A page entry ends the walk with a mapping. An invalid or reserved entry ends the walk with a fault. A page entry may appear at the first, second or third level, which gives a 16 MB, 256 KB or 4 KB mapping.

When a walk ends on a page entry, the block sets the referenced flag in that entry. For a write access it also sets the modified flag. It writes the entry back to the same address only when one of these flags actually changed. When translation is switched off, the address passes straight through with read and write access granted, and no memory traffic takes place. The walker handles one request at a time. Memory is reached through a plain word request channel. Each result is handed to a later permission-check stage as a one-cycle done pulse.

Top module: `pt_walker`

## Requirements
- R1: With `mmu_enable` low, an accepted request gives `done` in the cycle after acceptance, with `done_paddr` equal to the zero-extended virtual address, `done_bypass`=1 and `done_fault`=0, and no memory request is issued.
- R2: With translation on, the first memory read goes to (`ctx_table_ptr` << 4) + (`ctx_number` << 4).
- R3: Entry type is bits 1:0 (0 invalid, 1 table descriptor, 2 page entry, 3 reserved). A descriptor's next read address is ({entry[31:2],2'b00} << 4) plus 4 × index. The index is vaddr[31:24] at level 1, vaddr[23:18] at level 2 and vaddr[17:12] at level 3.
- R4: An invalid entry at any level ends the walk with `done_fault`=1, `done_fault_type`=1, and `done_level` set to the level at which it was read (0 for the context entry).
- R5: A reserved entry, a page entry in the context slot, or a descriptor at level 3 ends the walk with `done_fault_type`=4.
- R6: A page entry at level 1 gives `done_paddr` = ({entry[31:8],12'h000}) + vaddr[23:0] and `done_level`=1.
- R7: A page entry at level 2 gives `done_paddr` = ({entry[31:8],12'h000}) + vaddr[17:0] and `done_level`=2.
- R8: A page entry at level 3 gives `done_paddr` = ({entry[31:8],12'h000}) + vaddr[11:0] and `done_level`=3.
- R9: On a page entry, the referenced flag (bit 5) is set, and on a write the modified flag (bit 6) is set too. The updated entry is written to the address it was read from only if it differs from the fetched value. `done_entry` carries the updated entry, and faults write nothing.
- R10: Only one memory request is outstanding at a time. A request is held with stable address and direction until `mem_req_ready`. A read completes on `mem_rsp_valid` in a later cycle, and a write completes on acceptance.
- R11: `req_ready` is high only when the walker is idle, so requests presented while busy are ignored. `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mmu_enable | input | 1 | Translation on (1) or pass-through (0) |
| ctx_table_ptr | input | 32 | Context table pointer register value |
| ctx_number | input | 8 | Current context number |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Memory request is a write-back |
| mem_req_addr | output | 36 | Physical word address of entry |
| mem_req_wdata | output | 32 | Entry value for write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data (fetched entry) |
| done | output | 1 | One-cycle result pulse |
| done_paddr | output | 36 | Translated physical address |
| done_entry | output | 32 | Final entry (updated flags) or faulting entry |
| done_level | output | 2 | Level where the walk ended (0 = context) |
| done_bypass | output | 1 | Pass-through result with full access |
| done_fault | output | 1 | Walk ended in a fault |
| done_fault_type | output | 3 | Fault type: 1 invalid, 4 translation error |

## Verification
The bench builds the walker with its default widths: a 32-bit virtual address, 32-bit entries and an 8-bit context number, which give a 36-bit physical address. With these values, real page tables placed at known physical bases can exercise every index field and every leaf level. A bench memory with adjustable response latency and an alternating ready signal brings held requests and slow responses into reach. Within a single run it also covers the pass-through path, all five fault causes and each write-back case of the referenced and modified flags.

// File: rtl/pt_walk_pkg.sv
// Shared types and constants for the page table walker.
// Assumes 32-bit entries with type in bits 1:0, referenced in bit 5, modified in bit 6.
package pt_walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_CTX,
        ST_FETCH_L1,
        ST_FETCH_L2,
        ST_FETCH_L3,
        ST_UPDATE,
        ST_DONE
    } walk_state_e;

    localparam logic [1:0] ET_INVALID = 2'd0;
    localparam logic [1:0] ET_TABLE   = 2'd1;
    localparam logic [1:0] ET_PAGE    = 2'd2;
    localparam logic [1:0] ET_RSVD    = 2'd3;

    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;
    localparam int FRAME_LSB = 8;

    localparam logic [2:0] FT_NONE    = 3'd0;
    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_XLATE   = 3'd4;

endpackage

// File: rtl/pt_walk_agen.sv
// Entry address generator: context slot address at level 0, otherwise the
// child-table pointer of a descriptor plus the scaled index for that level.
// Assumes the level-3 index starts at bit PAGE_SHIFT with 6-bit level-2/3 indices.
module pt_walk_agen #(
    parameter int VA_W       = 32,
    parameter int ENT_W      = 32,
    parameter int CTX_W      = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 6
) (
    input  logic [1:0]         lvl,
    input  logic [VA_W-1:0]    vaddr,
    input  logic [ENT_W-1:0]   ctx_ptr,
    input  logic [CTX_W-1:0]   ctx_num,
    input  logic [ENT_W-3:0]   parent_ptr,
    output logic [ENT_W+3:0]   addr
);
    localparam int PA_W   = ENT_W + 4;
    localparam int L3_LSB = PAGE_SHIFT;
    localparam int L2_LSB = L3_LSB + IDX_W;
    localparam int L1_LSB = L2_LSB + IDX_W;
    localparam int L1_W   = VA_W - L1_LSB;

    logic [PA_W-1:0] table_base;

    // Pick the address of the next entry to read for the requested level.
    always_comb begin
        table_base = PA_W'({parent_ptr, 2'b00}) << 4;
        case (lvl)
            2'd0:    addr = (PA_W'(ctx_ptr) << 4) + (PA_W'(ctx_num) << 4);
            2'd1:    addr = table_base + PA_W'({vaddr[L1_LSB +: L1_W], 2'b00});
            2'd2:    addr = table_base + PA_W'({vaddr[L2_LSB +: IDX_W], 2'b00});
            default: addr = table_base + PA_W'({vaddr[L3_LSB +: IDX_W], 2'b00});
        endcase
    end

endmodule

// File: rtl/pt_walk_leaf.sv
// Leaf resolver: forms the physical address for a page entry found at a given
// level and computes the entry with referenced/modified flags applied.
// Assumes the frame field sits at bits ENT_W-1:8 and is scaled by 16.
module pt_walk_leaf #(
    parameter int VA_W       = 32,
    parameter int ENT_W      = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 6
) (
    input  logic [1:0]         lvl,
    input  logic [VA_W-1:0]    vaddr,
    input  logic [ENT_W-1:0]   entry,
    input  logic               is_write,
    output logic [ENT_W+3:0]   paddr,
    output logic [ENT_W-1:0]   upd_entry,
    output logic               need_wb
);
    import pt_walk_pkg::*;

    localparam int PA_W   = ENT_W + 4;
    localparam int L3_LSB = PAGE_SHIFT;
    localparam int L2_LSB = L3_LSB + IDX_W;
    localparam int L1_LSB = L2_LSB + IDX_W;

    logic [PA_W-1:0] frame;
    logic [PA_W-1:0] offset;

    // Select the in-page offset by mapping size and add it to the frame.
    always_comb begin
        frame = PA_W'({entry[ENT_W-1:FRAME_LSB], {FRAME_LSB{1'b0}}}) << 4;
        case (lvl)
            2'd1:    offset = PA_W'(vaddr[L1_LSB-1:0]);
            2'd2:    offset = PA_W'(vaddr[L2_LSB-1:0]);
            default: offset = PA_W'(vaddr[L3_LSB-1:0]);
        endcase
        paddr = frame + offset;
    end

    // Apply the usage flags and flag a write-back only if something changed.
    always_comb begin
        upd_entry = entry | (ENT_W'(1) << REF_BIT);
        if (is_write) begin
            upd_entry = upd_entry | (ENT_W'(1) << MOD_BIT);
        end
        need_wb = (upd_entry != entry);
    end

endmodule

// File: rtl/pt_walker.sv
// Page table walker top: one walk at a time through context entry and up to
// three table levels, with conditional flag write-back and a done pulse.
// Assumes memory answers each read with one mem_rsp_valid cycle after the
// request was accepted; writes complete on acceptance.
module pt_walker #(
    parameter int VA_W  = 32,
    parameter int ENT_W = 32,
    parameter int CTX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mmu_enable,
    input  logic [ENT_W-1:0]   ctx_table_ptr,
    input  logic [CTX_W-1:0]   ctx_number,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [ENT_W+3:0]   mem_req_addr,
    output logic [ENT_W-1:0]   mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_rdata,
    output logic               done,
    output logic [ENT_W+3:0]   done_paddr,
    output logic [ENT_W-1:0]   done_entry,
    output logic [1:0]         done_level,
    output logic               done_bypass,
    output logic               done_fault,
    output logic [2:0]         done_fault_type
);
    import pt_walk_pkg::*;

    localparam int PA_W = ENT_W + 4;

    walk_state_e       state_q;
    logic              pending_q;
    logic [VA_W-1:0]   vaddr_q;
    logic              write_q;
    logic [PA_W-1:0]   addr_q;
    logic [ENT_W-1:0]  entry_q;
    logic [PA_W-1:0]   paddr_q;
    logic [1:0]        level_q;
    logic              bypass_q;
    logic              fault_q;
    logic [2:0]        ftype_q;

    logic [1:0]        cur_lvl;
    logic [1:0]        gen_lvl;
    logic              fetching;
    logic              rsp_take;
    logic [PA_W-1:0]   gen_addr;
    logic [PA_W-1:0]   leaf_paddr;
    logic [ENT_W-1:0]  leaf_entry;
    logic              leaf_wb;
    logic [1:0]        rsp_type;
    walk_state_e       deeper_state;

    // Map the fetch state to its table level and to the level that follows.
    always_comb begin
        case (state_q)
            ST_FETCH_L1: begin cur_lvl = 2'd1; gen_lvl = 2'd2; deeper_state = ST_FETCH_L2; end
            ST_FETCH_L2: begin cur_lvl = 2'd2; gen_lvl = 2'd3; deeper_state = ST_FETCH_L3; end
            ST_FETCH_L3: begin cur_lvl = 2'd3; gen_lvl = 2'd3; deeper_state = ST_DONE;     end
            ST_FETCH_CTX: begin cur_lvl = 2'd0; gen_lvl = 2'd1; deeper_state = ST_FETCH_L1; end
            default:     begin cur_lvl = 2'd0; gen_lvl = 2'd0; deeper_state = ST_DONE;     end
        endcase
    end

    // Flags for the read phases and the response hand-off.
    always_comb begin
        fetching = (state_q == ST_FETCH_CTX) || (state_q == ST_FETCH_L1) ||
                   (state_q == ST_FETCH_L2)  || (state_q == ST_FETCH_L3);
        rsp_take = fetching && pending_q && mem_rsp_valid;
        rsp_type = mem_rsp_rdata[1:0];
    end

    pt_walk_agen #(
        .VA_W  (VA_W),
        .ENT_W (ENT_W),
        .CTX_W (CTX_W)
    ) u_agen (
        .lvl        (gen_lvl),
        .vaddr      ((state_q == ST_IDLE) ? req_vaddr : vaddr_q),
        .ctx_ptr    (ctx_table_ptr),
        .ctx_num    (ctx_number),
        .parent_ptr (mem_rsp_rdata[ENT_W-1:2]),
        .addr       (gen_addr)
    );

    pt_walk_leaf #(
        .VA_W  (VA_W),
        .ENT_W (ENT_W)
    ) u_leaf (
        .lvl       (cur_lvl),
        .vaddr     (vaddr_q),
        .entry     (mem_rsp_rdata),
        .is_write  (write_q),
        .paddr     (leaf_paddr),
        .upd_entry (leaf_entry),
        .need_wb   (leaf_wb)
    );

    // Walk sequencer: accept, fetch level by level, update, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pending_q <= 1'b0;
            vaddr_q   <= '0;
            write_q   <= 1'b0;
            addr_q    <= '0;
            entry_q   <= '0;
            paddr_q   <= '0;
            level_q   <= 2'd0;
            bypass_q  <= 1'b0;
            fault_q   <= 1'b0;
            ftype_q   <= FT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q  <= req_vaddr;
                        write_q  <= req_write;
                        fault_q  <= 1'b0;
                        ftype_q  <= FT_NONE;
                        level_q  <= 2'd0;
                        entry_q  <= '0;
                        if (!mmu_enable) begin
                            bypass_q <= 1'b1;
                            paddr_q  <= PA_W'(req_vaddr);
                            state_q  <= ST_DONE;
                        end else begin
                            bypass_q <= 1'b0;
                            paddr_q  <= '0;
                            addr_q   <= gen_addr;
                            state_q  <= ST_FETCH_CTX;
                        end
                    end
                end
                ST_FETCH_CTX, ST_FETCH_L1, ST_FETCH_L2, ST_FETCH_L3: begin
                    if (!pending_q) begin
                        if (mem_req_ready) begin
                            pending_q <= 1'b1;
                        end
                    end else if (rsp_take) begin
                        pending_q <= 1'b0;
                        level_q   <= cur_lvl;
                        if ((rsp_type == ET_TABLE) && (state_q != ST_FETCH_L3)) begin
                            addr_q  <= gen_addr;
                            state_q <= deeper_state;
                        end else if ((rsp_type == ET_PAGE) && (state_q != ST_FETCH_CTX)) begin
                            entry_q <= leaf_entry;
                            paddr_q <= leaf_paddr;
                            state_q <= leaf_wb ? ST_UPDATE : ST_DONE;
                        end else begin
                            entry_q <= mem_rsp_rdata;
                            fault_q <= 1'b1;
                            ftype_q <= (rsp_type == ET_INVALID) ? FT_INVALID : FT_XLATE;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_UPDATE: begin
                    if (mem_req_ready) begin
                        state_q <= ST_DONE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Drive the memory channel and the result interface from registered state.
    always_comb begin
        req_ready       = (state_q == ST_IDLE);
        mem_req_valid   = (fetching && !pending_q) || (state_q == ST_UPDATE);
        mem_req_write   = (state_q == ST_UPDATE);
        mem_req_addr    = addr_q;
        mem_req_wdata   = entry_q;
        done            = (state_q == ST_DONE);
        done_paddr      = paddr_q;
        done_entry      = entry_q;
        done_level      = level_q;
        done_bypass     = bypass_q;
        done_fault      = fault_q;
        done_fault_type = ftype_q;
    end

endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and result checker for pt_walker, attached by bind.
// Assumes the same parameters as the walker it watches.
module pt_walker_chk #(
    parameter int VA_W  = 32,
    parameter int ENT_W = 32,
    parameter int CTX_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mmu_enable,
    input logic [ENT_W-1:0]   ctx_table_ptr,
    input logic [CTX_W-1:0]   ctx_number,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VA_W-1:0]    req_vaddr,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic               mem_req_write,
    input logic [ENT_W+3:0]   mem_req_addr,
    input logic [ENT_W-1:0]   mem_req_wdata,
    input logic               done,
    input logic [ENT_W+3:0]   done_paddr,
    input logic [ENT_W-1:0]   done_entry,
    input logic [1:0]         done_level,
    input logic               done_bypass,
    input logic               done_fault,
    input logic [2:0]         done_fault_type
);
    localparam int PA_W = ENT_W + 4;

    logic [VA_W-1:0] seen_vaddr;
    logic [PA_W-1:0] ctx_slot;

    // Remember the virtual address of the request that was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_vaddr <= '0;
        end else if (req_valid && req_ready) begin
            seen_vaddr <= req_vaddr;
        end
    end

    // Context slot address as the requirement states it.
    always_comb begin
        ctx_slot = (PA_W'(ctx_table_ptr) << 4) + (PA_W'(ctx_number) << 4);
    end

    AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_bypass |-> (done_paddr == PA_W'(seen_vaddr)) && !done_fault); // R1

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !mmu_enable |=> done && !mem_req_valid); // R1

    AST_CTX_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && mmu_enable |=>
            mem_req_valid && !mem_req_write && (mem_req_addr == $past(ctx_slot))); // R2

    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault |-> (done_fault_type == 3'd1) || (done_fault_type == 3'd4)); // R4

    AST_LEAF_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_fault && !done_bypass |->
            done_entry[5] && (done_entry[1:0] == 2'd2) && (done_level != 2'd0)); // R9

    AST_WB_CARRIES_REF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[5] && (mem_req_wdata[1:0] == 2'd2)); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R11

endmodule

bind pt_walker pt_walker_chk #(
    .VA_W  (VA_W),
    .ENT_W (ENT_W),
    .CTX_W (CTX_W)
) u_pt_walker_chk (.*);

// File: tb/test_pt_walker.sv
// Directed bench for pt_walker with a latency-configurable memory model.
module test_pt_walker;
    localparam int VA_W  = 32;
    localparam int ENT_W = 32;
    localparam int CTX_W = 8;
    localparam int PA_W  = ENT_W + 4;

    localparam logic [31:0] CTX_PTR = 32'h0000_1000;
    localparam logic [7:0]  CTX_NUM = 8'h03;
    localparam logic [35:0] CTX_A   = 36'h0_0001_0030;
    localparam logic [35:0] L1_BASE = 36'h0_0002_0000;
    localparam logic [35:0] L2_BASE = 36'h0_0003_0000;
    localparam logic [35:0] L3_BASE = 36'h0_0004_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mmu_enable = 1'b1;
    logic [ENT_W-1:0] ctx_table_ptr = CTX_PTR;
    logic [CTX_W-1:0] ctx_number = CTX_NUM;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_write = 1'b0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b1;
    logic mem_req_write;
    logic [PA_W-1:0] mem_req_addr;
    logic [ENT_W-1:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [ENT_W-1:0] mem_rsp_rdata = '0;
    logic done;
    logic [PA_W-1:0] done_paddr;
    logic [ENT_W-1:0] done_entry;
    logic [1:0] done_level;
    logic done_bypass;
    logic done_fault;
    logic [2:0] done_fault_type;

    always #4 clk = ~clk;

    pt_walker #(.VA_W(VA_W), .ENT_W(ENT_W), .CTX_W(CTX_W)) i_pt_walker (
        .clk, .rst_n, .mmu_enable, .ctx_table_ptr, .ctx_number,
        .req_valid, .req_ready, .req_vaddr, .req_write,
        .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr, .mem_req_wdata,
        .mem_rsp_valid, .mem_rsp_rdata,
        .done, .done_paddr, .done_entry, .done_level, .done_bypass, .done_fault, .done_fault_type
    );

    // Memory model: tables from tasks, write-backs kept per epoch.
    logic [31:0] tbl [logic [35:0]];
    logic [31:0] wb  [logic [35:0]];
    int          wb_ep [logic [35:0]];
    int          epoch = 0;
    bit          stall_mode = 1'b0;
    int          lat_cfg = 0;
    int          n_reads = 0;
    int          n_writes = 0;
    logic [35:0] rd_log [0:7];
    logic [35:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    bit          pend = 1'b0;
    logic [35:0] pend_addr = '0;
    int          lat = 0;

    function automatic logic [31:0] mem_word(input logic [35:0] a);
        if (wb.exists(a) && wb_ep[a] == epoch) return wb[a];
        if (tbl.exists(a)) return tbl[a];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                wb[mem_req_addr] = mem_req_wdata;
                wb_ep[mem_req_addr] = epoch;
                n_writes = n_writes + 1;
                last_wr_addr = mem_req_addr;
                last_wr_data = mem_req_wdata;
            end else begin
                rd_log[n_reads % 8] = mem_req_addr;
                n_reads = n_reads + 1;
                pend = 1'b1;
                pend_addr = mem_req_addr;
                lat = lat_cfg;
            end
        end else if (pend) begin
            if (lat == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem_word(pend_addr);
                pend = 1'b0;
            end else begin
                lat = lat - 1;
            end
        end
    end

    int n_checks = 0;
    int n_err = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] l1a(input logic [31:0] va);
        return L1_BASE + 36'(va[31:24]) * 4;
    endfunction
    function automatic logic [35:0] l2a(input logic [31:0] va);
        return L2_BASE + 36'(va[23:18]) * 4;
    endfunction
    function automatic logic [35:0] l3a(input logic [31:0] va);
        return L3_BASE + 36'(va[17:12]) * 4;
    endfunction
    function automatic logic [35:0] frame_of(input logic [31:0] e);
        return {e[31:8], 12'h000};
    endfunction

    task automatic fresh();
        epoch++;
        tbl.delete();
    endtask

    task automatic map_ctx();
        tbl[CTX_A] = 32'h0000_2001;
    endtask
    task automatic map1(input logic [31:0] va, input logic [31:0] e);
        fresh(); map_ctx(); tbl[l1a(va)] = e;
    endtask
    task automatic map2(input logic [31:0] va, input logic [31:0] e);
        map1(va, 32'h0000_3001); tbl[l2a(va)] = e;
    endtask
    task automatic map3(input logic [31:0] va, input logic [31:0] e);
        map2(va, 32'h0000_4001); tbl[l3a(va)] = e;
    endtask

    logic [35:0] r_paddr;
    logic [31:0] r_entry;
    logic [1:0]  r_level;
    logic        r_bypass, r_fault, r_after;
    logic [2:0]  r_ftype;
    int          r_cyc, r_reads, r_writes, base_rd;

    // One walk; optional poke presents a second request while busy.
    task automatic walk(input logic [31:0] va, input bit wr, input bit poke);
        int b_rd = n_reads;
        int b_wr = n_writes;
        base_rd = n_reads;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        r_cyc = 0;
        if (poke) begin
            chk("R11", "req_ready while busy", 64'(req_ready), 64'd0);
            req_valid = 1'b1; req_vaddr = va ^ 32'hFFFF_F000;
        end
        while (!done && r_cyc < 2000) begin
            @(negedge clk);
            req_valid = 1'b0;
            r_cyc++;
        end
        if (!done) chk("R11", "walk timeout", 64'd0, 64'd1);
        r_paddr = done_paddr; r_entry = done_entry; r_level = done_level;
        r_bypass = done_bypass; r_fault = done_fault; r_ftype = done_fault_type;
        @(negedge clk);
        r_after = done;
        repeat (4) @(negedge clk);
        r_reads = n_reads - b_rd;
        r_writes = n_writes - b_wr;
    endtask

    task automatic t_reset();
        chk("R11", "reset req_ready", 64'(req_ready), 64'd1);
        chk("R11", "reset done", 64'(done), 64'd0);
        chk("R10", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_bypass();
        mmu_enable = 1'b0;
        walk(32'hDEAD_BEEF, 1'b1, 1'b0);
        chk("R1", "bypass latency", 64'(r_cyc), 64'd0);
        chk("R1", "bypass paddr", 64'(r_paddr), 64'h0_DEAD_BEEF);
        chk("R1", "bypass flag", 64'(r_bypass), 64'd1);
        chk("R1", "bypass no fault", 64'(r_fault), 64'd0);
        chk("R1", "bypass no memory", 64'(r_reads + r_writes), 64'd0);
        mmu_enable = 1'b1;
    endtask

    task automatic t_l3_read();
        logic [31:0] va = 32'h054A_7123;
        logic [31:0] e  = 32'h0123_450E;
        map3(va, e);
        walk(va, 1'b0, 1'b0);
        chk("R2", "context read addr", 64'(rd_log[base_rd % 8]), 64'(CTX_A));
        chk("R3", "level-1 read addr", 64'(rd_log[(base_rd + 1) % 8]), 64'(l1a(va)));
        chk("R3", "level-2 read addr", 64'(rd_log[(base_rd + 2) % 8]), 64'(l2a(va)));
        chk("R3", "level-3 read addr", 64'(rd_log[(base_rd + 3) % 8]), 64'(l3a(va)));
        chk("R8", "4K paddr", 64'(r_paddr), 64'(frame_of(e) + 36'(va[11:0])));
        chk("R8", "4K level", 64'(r_level), 64'd3);
        chk("R9", "ref set entry", 64'(r_entry), 64'(e | 32'h20));
        chk("R9", "one write-back", 64'(r_writes), 64'd1);
        chk("R9", "write-back addr", 64'(last_wr_addr), 64'(l3a(va)));
        chk("R9", "write-back data", 64'(last_wr_data), 64'(e | 32'h20));
        chk("R11", "done one cycle", 64'(r_after), 64'd0);
    endtask

    task automatic t_flags();
        logic [31:0] va = 32'h7700_1ABC;
        map3(va, 32'h0777_772E);
        walk(va, 1'b1, 1'b0);
        chk("R9", "write sets modified", 64'(r_entry), 64'h0777_776E);
        chk("R9", "write-back on modified", 64'(r_writes), 64'd1);
        chk("R9", "memory holds modified", 64'(mem_word(l3a(va))), 64'h0777_776E);
        map3(va, 32'h0777_772E);
        walk(va, 1'b0, 1'b0);
        chk("R9", "read ref already set entry", 64'(r_entry), 64'h0777_772E);
        chk("R9", "read no write-back", 64'(r_writes), 64'd0);
        map3(va, 32'h0777_776E);
        walk(va, 1'b1, 1'b0);
        chk("R9", "write both set no write-back", 64'(r_writes), 64'd0);
    endtask

    task automatic t_l1_l2();
        logic [31:0] va1 = 32'hA1B2_C3D4;
        logic [31:0] e1  = 32'h000A_BC62;
        logic [31:0] va2 = 32'h3C7F_E9A5;
        logic [31:0] e2  = 32'h0555_5562;
        map1(va1, e1);
        walk(va1, 1'b0, 1'b0);
        chk("R6", "16M paddr", 64'(r_paddr), 64'(frame_of(e1) + 36'(va1[23:0])));
        chk("R6", "16M level", 64'(r_level), 64'd1);
        chk("R6", "16M reads", 64'(r_reads), 64'd2);
        map2(va2, e2);
        walk(va2, 1'b0, 1'b0);
        chk("R7", "256K paddr", 64'(r_paddr), 64'(frame_of(e2) + 36'(va2[17:0])));
        chk("R7", "256K level", 64'(r_level), 64'd2);
        chk("R7", "256K reads", 64'(r_reads), 64'd3);
    endtask

    task automatic t_faults();
        logic [31:0] va = 32'h1234_5678;
        fresh();
        walk(va, 1'b1, 1'b0);
        chk("R4", "invalid ctx type", 64'({r_fault, r_ftype}), 64'h9);
        chk("R4", "invalid ctx level", 64'(r_level), 64'd0);
        map2(va, 32'h0000_0000);
        walk(va, 1'b1, 1'b0);
        chk("R4", "invalid L2 type", 64'({r_fault, r_ftype}), 64'h9);
        chk("R4", "invalid L2 level", 64'(r_level), 64'd2);
        chk("R9", "fault no write-back", 64'(r_writes), 64'd0);
        map1(va, 32'h0000_3003);
        walk(va, 1'b0, 1'b0);
        chk("R5", "reserved L1", 64'({r_fault, r_ftype, r_level}), 64'h31);
        fresh(); tbl[CTX_A] = 32'h0000_2002;
        walk(va, 1'b0, 1'b0);
        chk("R5", "leaf in context", 64'({r_fault, r_ftype, r_level}), 64'h30);
        map3(va, 32'h0000_5001);
        walk(va, 1'b0, 1'b0);
        chk("R5", "descriptor at L3", 64'({r_fault, r_ftype, r_level}), 64'h33);
    endtask

    task automatic t_stall();
        logic [31:0] va = 32'h054A_7123;
        logic [31:0] e  = 32'h0123_456E;
        stall_mode = 1'b1; lat_cfg = 3;
        map3(va, e);
        walk(va, 1'b1, 1'b1);
        chk("R10", "stalled paddr", 64'(r_paddr), 64'(frame_of(e) + 36'(va[11:0])));
        chk("R10", "each read once", 64'(r_reads), 64'd4);
        chk("R11", "poke ignored, no extra walk", 64'(r_reads + r_writes), 64'd4);
        chk("R11", "stalled done one cycle", 64'(r_after), 64'd0);
        stall_mode = 1'b0; lat_cfg = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_bypass();
        t_l3_read();
        t_flags();
        t_l1_l2();
        t_faults();
        t_stall();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_checks + 1);
        $finish;
    end

endmodule